// File: doc/BRIEF.md
# I2C EEPROM slave protocol engine

This block is the bus-facing protocol engine of a byte-addressed serial memory. It runs on a fast system clock and oversamples the two-wire bus lines. Each line passes through a two-flop synchronizer. The engine detects START and STOP conditions and receives the slave address byte. It compares that byte against a fixed 4-bit prefix followed by three strap inputs, then runs the write, read and acknowledge sequences. The engine never drives SDA high. It only asserts an output enable, and that enable pulls the open-drain line low.

A write session carries two memory-address bytes, and the top three bits of the first byte are ignored. It may then carry any number of data bytes. The engine passes each accepted data byte to a separate page-buffer block as a single-cycle request with its address and data. Data addresses advance inside a 32-byte page and wrap back to the page start. A commit pulse tells the page buffer to start its internal write cycle. While that cycle runs, the page buffer raises a busy input, and the engine then refuses its own address so that the master can poll.

For reads, the engine presents a current-address pointer to a memory port and shifts out the byte it gets back. The read can start from a freshly loaded address (selective read) or from wherever the pointer was left (immediate read). Each master ACK advances the read across the whole memory, wrapping from the last location to 0. The system clock must run at least 8 times faster than SCL.

Top module: `i2c_eeprom_slave`

## Requirements
- R1: A START is SDA falling while SCL is high, and a STOP is SDA rising while SCL is high. Until a START is seen, the engine never drives SDA and never issues write requests, even when complete bytes are clocked on the bus.
- R2: The address byte is accepted only when its upper seven bits equal 1010 followed by strap_i[2], strap_i[1], strap_i[0]. Bit 0 selects the direction, with 1 for read and 0 for write. On a mismatch, SDA stays released for the ACK clock and for the rest of the transfer.
- R3: During the 9th SCL clock of each accepted byte sent by the master, the engine pulls SDA low. Its SDA driver changes only while SCL is low.
- R4: The first address byte supplies address bits 12:8 from its bits 4:0, and its bits 7:5 are ignored. The second address byte supplies address bits 7:0.
- R5: Every accepted data byte produces one single-cycle wr_req_o with wr_addr_o and wr_data_o. Each later byte in the same session uses the next address within the 32-byte page, where address bits 4:0 wrap from 31 to 0 and bits 12:5 stay unchanged.
- R6: wr_commit_o pulses once at the STOP that ends a session in which at least one data byte was accepted. It does not pulse for sessions without accepted data.
- R7: While wr_busy_i is high, the engine gives NoACK to its own address byte, for both reads and writes.
- R8: wp_i is sampled on the SCL falling edge that ends the ACK of the second address byte. If it is sampled high, the first data byte gets NoACK, no wr_req_o is issued, and no commit follows.
- R9: A read that follows a write-address phase and a repeated START returns the byte at the newly loaded address. A read with no address phase returns the byte at the current address.
- R10: In a read, a master ACK makes the engine send the byte at the next address, wrapping from 8191 to 0. A master NoACK ends the read, and SDA stays released until the next START.
- R11: After each byte is written or read, the current address points to the following location. For writes, the following location is the in-page successor.
- R12: A START or STOP in the middle of a transfer aborts it, and no write request results. The current address changes only if the second address byte was completed. Accepted data is still committed when the session is ended by a repeated START instead of a STOP.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least 8x SCL |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Bus clock line as seen at the pin |
| sda_i | input | 1 | Bus data line as seen at the pin |
| sda_oe_o | output | 1 | 1 pulls SDA low; 0 releases it |
| strap_i | input | 3 | Device-select strap pins, compared with address bits 3:1 |
| wp_i | input | 1 | Write-protect input |
| wr_busy_i | input | 1 | Internal write cycle in progress |
| wr_req_o | output | 1 | One-cycle pulse per accepted data byte |
| wr_addr_o | output | 13 | Memory address of the data byte |
| wr_data_o | output | 8 | Accepted data byte |
| wr_commit_o | output | 1 | One-cycle pulse to start the internal write |
| rd_addr_o | output | 13 | Current address presented to the memory port |
| rd_data_i | input | 8 | Memory byte at rd_addr_o |

## Verification
Two situations are the hardest to reach. The first is the write-protect strobe: wp_i matters only on one SCL falling edge, the one that closes the ACK of the second address byte. The bench holds wp_i high across a full write, expects ACKs for the address bytes and NoACK for the data, and confirms that neither a request nor a commit appears. The second is the read wrap at the top location. The bench gets there with a selective read at address 8191 followed by two master ACKs, and a later immediate read shows where the pointer was left. Aborts are driven by cutting bytes short with STOP or a repeated START mid-byte, and a follow-up read then shows whether the address pointer moved.

// File: rtl/i2c_ee_pkg.sv
`timescale 1ns/1ps
package i2c_ee_pkg;

  typedef enum logic [2:0] {
    ST_IDLE   = 3'd0,
    ST_RX     = 3'd1,
    ST_RX_ACK = 3'd2,
    ST_TX     = 3'd3,
    ST_TX_ACK = 3'd4,
    ST_WAIT   = 3'd5
  } ee_state_t;

  typedef enum logic [1:0] {
    K_DEV  = 2'd0,
    K_AHI  = 2'd1,
    K_ALO  = 2'd2,
    K_DATA = 2'd3
  } ee_kind_t;

  function automatic ee_kind_t next_kind(ee_kind_t k);
    case (k)
      K_DEV:   return K_AHI;
      K_AHI:   return K_ALO;
      default: return K_DATA;
    endcase
  endfunction

  function automatic logic addr_match(logic [7:0] b, logic [3:0] prefix,
                                      logic [2:0] strap);
    return b[7:1] == {prefix, strap};
  endfunction

endpackage

// File: rtl/i2c_ee_sync.sv
`timescale 1ns/1ps
module i2c_ee_sync (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_s,
  output logic sda_s,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_det,
  output logic stop_det
);
  logic [1:0] scl_ff, sda_ff;
  logic       scl_d, sda_d;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_ff <= 2'b11;
      sda_ff <= 2'b11;
      scl_d  <= 1'b1;
      sda_d  <= 1'b1;
    end else begin
      scl_ff <= {scl_ff[0], scl_i};
      sda_ff <= {sda_ff[0], sda_i};
      scl_d  <= scl_ff[1];
      sda_d  <= sda_ff[1];
    end
  end

  assign scl_s     = scl_ff[1];
  assign sda_s     = sda_ff[1];
  assign scl_rise  = scl_s & ~scl_d;
  assign scl_fall  = ~scl_s & scl_d;
  assign start_det = scl_s & scl_d & sda_d & ~sda_s;
  assign stop_det  = scl_s & scl_d & ~sda_d & sda_s;
endmodule

// File: rtl/i2c_ee_addr.sv
`timescale 1ns/1ps
module i2c_ee_addr #(
  parameter int ADDR_W     = 13,
  parameter int PAGE_BYTES = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ld_hi,
  input  logic              ld_lo,
  input  logic              inc_page,
  input  logic              inc_full,
  input  logic [7:0]        byte_i,
  output logic [ADDR_W-1:0] addr_o
);
  localparam int PB   = $clog2(PAGE_BYTES);
  localparam int HI_W = ADDR_W - 8;
  localparam logic [ADDR_W-1:0] ONE_A = 1;
  localparam logic [PB-1:0]     ONE_P = 1;

  // successor inside the page: only the low page-offset bits advance
  function automatic logic [ADDR_W-1:0] page_next(logic [ADDR_W-1:0] a);
    logic [ADDR_W-1:0] r;
    r = a;
    r[PB-1:0] = a[PB-1:0] + ONE_P;
    return r;
  endfunction

  // successor across the whole memory, wrapping at the top
  function automatic logic [ADDR_W-1:0] mem_next(logic [ADDR_W-1:0] a);
    return a + ONE_A;
  endfunction

  logic [HI_W-1:0]   hi_q;
  logic [ADDR_W-1:0] ptr_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hi_q  <= '0;
      ptr_q <= '0;
    end else begin
      if (ld_hi)    hi_q  <= byte_i[HI_W-1:0];
      if (ld_lo)    ptr_q <= {hi_q, byte_i};
      else if (inc_page) ptr_q <= page_next(ptr_q);
      else if (inc_full) ptr_q <= mem_next(ptr_q);
    end
  end

  assign addr_o = ptr_q;
endmodule

// File: rtl/i2c_eeprom_slave.sv
`timescale 1ns/1ps
module i2c_eeprom_slave #(
  parameter int         ADDR_W     = 13,
  parameter int         PAGE_BYTES = 32,
  parameter logic [3:0] DEV_PREFIX = 4'b1010
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              scl_i,
  input  logic              sda_i,
  output logic              sda_oe_o,
  input  logic [2:0]        strap_i,
  input  logic              wp_i,
  input  logic              wr_busy_i,
  output logic              wr_req_o,
  output logic [ADDR_W-1:0] wr_addr_o,
  output logic [7:0]        wr_data_o,
  output logic              wr_commit_o,
  output logic [ADDR_W-1:0] rd_addr_o,
  input  logic [7:0]        rd_data_i
);
  import i2c_ee_pkg::*;

  localparam logic [3:0] BITS_DONE = 4'd8;

  // bus events
  logic scl_s, sda_s, scl_rise, scl_fall, start_det, stop_det;

  i2c_ee_sync u_sync (
    .clk       (clk),
    .rst_n     (rst_n),
    .scl_i     (scl_i),
    .sda_i     (sda_i),
    .scl_s     (scl_s),
    .sda_s     (sda_s),
    .scl_rise  (scl_rise),
    .scl_fall  (scl_fall),
    .start_det (start_det),
    .stop_det  (stop_det)
  );

  ee_state_t         state_q;
  ee_kind_t          kind_q;
  logic [3:0]        cnt_q;
  logic [7:0]        rx_q;
  logic [7:0]        tx_q;
  logic              rw_q;
  logic              wp_lat_q;
  logic              mack_q;
  logic              pend_q;
  logic              oe_q;
  logic              req_q;
  logic              commit_q;
  logic [ADDR_W-1:0] waddr_q;
  logic [7:0]        wdata_q;
  logic [ADDR_W-1:0] ptr;

  // named internal events
  logic byte_end, rx_ack, data_take, dev_ack_ev, tx_done, ld_hi, ld_lo;

  assign byte_end   = (state_q == ST_RX) && scl_fall && (cnt_q == BITS_DONE)
                      && !start_det && !stop_det;
  assign tx_done    = (state_q == ST_TX) && scl_fall && (cnt_q == BITS_DONE)
                      && !start_det && !stop_det;

  always_comb begin
    case (kind_q)
      K_DEV:   rx_ack = addr_match(rx_q, DEV_PREFIX, strap_i) && !wr_busy_i;
      K_DATA:  rx_ack = !wp_lat_q;
      default: rx_ack = 1'b1;
    endcase
  end

  assign dev_ack_ev = byte_end && (kind_q == K_DEV) && rx_ack;
  assign data_take  = byte_end && (kind_q == K_DATA) && rx_ack;
  assign ld_hi      = byte_end && (kind_q == K_AHI);
  assign ld_lo      = byte_end && (kind_q == K_ALO);

  i2c_ee_addr #(.ADDR_W(ADDR_W), .PAGE_BYTES(PAGE_BYTES)) u_addr (
    .clk      (clk),
    .rst_n    (rst_n),
    .ld_hi    (ld_hi),
    .ld_lo    (ld_lo),
    .inc_page (data_take),
    .inc_full (tx_done),
    .byte_i   (rx_q),
    .addr_o   (ptr)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q  <= ST_IDLE;
      kind_q   <= K_DEV;
      cnt_q    <= '0;
      rx_q     <= '0;
      tx_q     <= '0;
      rw_q     <= 1'b0;
      wp_lat_q <= 1'b0;
      mack_q   <= 1'b0;
      pend_q   <= 1'b0;
      oe_q     <= 1'b0;
      req_q    <= 1'b0;
      commit_q <= 1'b0;
      waddr_q  <= '0;
      wdata_q  <= '0;
    end else begin
      req_q    <= 1'b0;
      commit_q <= 1'b0;
      if (start_det || stop_det) begin
        // any condition aborts; pending write data is still committed
        oe_q     <= 1'b0;
        cnt_q    <= '0;
        kind_q   <= K_DEV;
        wp_lat_q <= 1'b0;
        commit_q <= pend_q;
        pend_q   <= 1'b0;
        state_q  <= start_det ? ST_RX : ST_IDLE;
      end else begin
        case (state_q)
          ST_RX: begin
            if (scl_rise) begin
              rx_q  <= {rx_q[6:0], sda_s};
              cnt_q <= cnt_q + 4'd1;
            end else if (byte_end) begin
              cnt_q <= '0;
              if (kind_q == K_DEV) rw_q <= rx_q[0];
              if (rx_ack) begin
                oe_q    <= 1'b1;
                state_q <= ST_RX_ACK;
              end else begin
                state_q <= ST_WAIT;
              end
              if (data_take) begin
                req_q   <= 1'b1;
                waddr_q <= ptr;
                wdata_q <= rx_q;
                pend_q  <= 1'b1;
              end
            end
          end
          ST_RX_ACK: begin
            if (scl_fall) begin
              cnt_q <= '0;
              if (kind_q == K_ALO) wp_lat_q <= wp_i;
              if (kind_q == K_DEV && rw_q) begin
                state_q <= ST_TX;
                oe_q    <= ~rd_data_i[7];
                tx_q    <= {rd_data_i[6:0], 1'b0};
              end else begin
                oe_q    <= 1'b0;
                state_q <= ST_RX;
                kind_q  <= next_kind(kind_q);
              end
            end
          end
          ST_TX: begin
            if (scl_rise) begin
              cnt_q <= cnt_q + 4'd1;
            end else if (tx_done) begin
              oe_q    <= 1'b0;
              cnt_q   <= '0;
              state_q <= ST_TX_ACK;
            end else if (scl_fall) begin
              oe_q <= ~tx_q[7];
              tx_q <= {tx_q[6:0], 1'b0};
            end
          end
          ST_TX_ACK: begin
            if (scl_rise) begin
              mack_q <= ~sda_s;
            end else if (scl_fall) begin
              if (mack_q) begin
                state_q <= ST_TX;
                oe_q    <= ~rd_data_i[7];
                tx_q    <= {rd_data_i[6:0], 1'b0};
              end else begin
                state_q <= ST_WAIT;
              end
            end
          end
          default: ;
        endcase
      end
    end
  end

  assign sda_oe_o    = oe_q;
  assign wr_req_o    = req_q;
  assign wr_addr_o   = waddr_q;
  assign wr_data_o   = wdata_q;
  assign wr_commit_o = commit_q;
  assign rd_addr_o   = ptr;
endmodule

// File: rtl/i2c_eeprom_slave_chk.sv
`timescale 1ns/1ps
module i2c_eeprom_slave_chk #(
  parameter int ADDR_W = 13
) (
  input logic                   clk,
  input logic                   rst_n,
  input logic                   scl_s,
  input logic                   sda_oe_o,
  input logic                   start_det,
  input logic                   stop_det,
  input logic                   dev_ack_ev,
  input logic                   wr_busy_i,
  input logic                   wr_req_o,
  input logic                   wr_commit_o,
  input logic                   tx_done,
  input logic [ADDR_W-1:0]      rd_addr_o,
  input i2c_ee_pkg::ee_state_t  state_q
);
  import i2c_ee_pkg::*;

  // R1
  cond_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(start_det && stop_det));

  // R1
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_IDLE) |-> !sda_oe_o);

  // R3
  oe_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(sda_oe_o) |-> !scl_s);

  // R7
  busy_nack_chk: assert property (@(posedge clk) disable iff (!rst_n)
    dev_ack_ev |-> !wr_busy_i);

  // R5
  req_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_req_o |=> !wr_req_o);

  // R6
  commit_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_commit_o |-> !wr_req_o);

  // R10
  rd_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tx_done |=> (rd_addr_o == $past(rd_addr_o) + 1'b1));
endmodule

bind i2c_eeprom_slave i2c_eeprom_slave_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .scl_s       (scl_s),
  .sda_oe_o    (sda_oe_o),
  .start_det   (start_det),
  .stop_det    (stop_det),
  .dev_ack_ev  (dev_ack_ev),
  .wr_busy_i   (wr_busy_i),
  .wr_req_o    (wr_req_o),
  .wr_commit_o (wr_commit_o),
  .tx_done     (tx_done),
  .rd_addr_o   (rd_addr_o),
  .state_q     (state_q)
);

// File: tb/i2c_eeprom_slave_tb.sv
`timescale 1ns/1ps
module i2c_eeprom_slave_tb;
  localparam int CLK_PERIOD = 10;
  localparam int Q          = 20 * CLK_PERIOD;
  localparam int WDOG       = 150000;
  localparam logic [2:0] STRAP = 3'b101;
  localparam logic [7:0] DEV_W = {4'b1010, STRAP, 1'b0};
  localparam logic [7:0] DEV_R = {4'b1010, STRAP, 1'b1};

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        scl = 1'b1;
  logic        sda_m = 1'b1;
  logic        wp = 1'b0;
  logic        busy = 1'b0;
  logic        sda_oe;
  logic        wr_req, wr_commit;
  logic [12:0] wr_addr, rd_addr;
  logic [7:0]  wr_data, rd_data;
  wire         sda_line = sda_m & ~sda_oe;

  int errors = 0;
  int checks = 0;
  int n_req = 0;
  int n_com = 0;
  logic [12:0] log_a [0:15];
  logic [7:0]  log_d [0:15];

  always #(CLK_PERIOD/2) clk = ~clk;

  // memory model: byte value is a fixed function of its address
  function automatic logic [7:0] pat(logic [12:0] a);
    return a[7:0] ^ {a[12:8], 3'b101};
  endfunction
  assign rd_data = pat(rd_addr);

  i2c_eeprom_slave u_dut (
    .clk         (clk),
    .rst_n       (rst_n),
    .scl_i       (scl),
    .sda_i       (sda_line),
    .sda_oe_o    (sda_oe),
    .strap_i     (STRAP),
    .wp_i        (wp),
    .wr_busy_i   (busy),
    .wr_req_o    (wr_req),
    .wr_addr_o   (wr_addr),
    .wr_data_o   (wr_data),
    .wr_commit_o (wr_commit),
    .rd_addr_o   (rd_addr),
    .rd_data_i   (rd_data)
  );

  always @(negedge clk) begin
    if (wr_req) begin
      if (n_req < 16) begin
        log_a[n_req] = wr_addr;
        log_d[n_req] = wr_data;
      end
      n_req = n_req + 1;
    end
    if (wr_commit) n_com = n_com + 1;
  end

  task automatic chk(input logic ok, input string req, input int act, input int exp);
    checks = checks + 1;
    if (!ok) begin
      errors = errors + 1;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic bus_start();
    sda_m = 1'b1; #Q; scl = 1'b1; #Q; sda_m = 1'b0; #Q; scl = 1'b0; #Q;
  endtask

  task automatic bus_stop();
    scl = 1'b0; sda_m = 1'b0; #Q; scl = 1'b1; #Q; sda_m = 1'b1; #Q;
  endtask

  task automatic bit_out(input logic b);
    scl = 1'b0; sda_m = b; #Q; scl = 1'b1; #(2*Q); scl = 1'b0; #Q;
  endtask

  task automatic send_byte(input logic [7:0] b, output logic acked);
    for (int i = 7; i >= 0; i--) bit_out(b[i]);
    sda_m = 1'b1; #Q; scl = 1'b1; #Q; acked = ~sda_line; #Q; scl = 1'b0; #Q;
  endtask

  task automatic recv_byte(input logic mack, output logic [7:0] b);
    sda_m = 1'b1;
    for (int i = 7; i >= 0; i--) begin
      #Q; scl = 1'b1; #Q; b[i] = sda_line; #Q; scl = 1'b0; #Q;
    end
    sda_m = ~mack; #Q; scl = 1'b1; #(2*Q); scl = 1'b0; #Q; sda_m = 1'b1;
  endtask

  task automatic t_reset();
    #(CLK_PERIOD/2);
    chk(sda_oe == 1'b0, "R1 reset sda_oe", sda_oe, 0);
    chk(wr_req == 1'b0 && wr_commit == 1'b0, "R6 reset pulses", wr_req, 0);
  endtask

  task automatic t_no_start();
    logic a; int r0;
    r0 = n_req;
    scl = 1'b0; #Q;
    send_byte(DEV_W, a);
    chk(a == 1'b0, "R1 no ACK without START", a, 0);
    send_byte(8'h00, a);
    chk(a == 1'b0 && n_req == r0, "R1 bytes ignored without START", n_req, r0);
    bus_stop();
  endtask

  task automatic t_bad_addr();
    logic a; int r0;
    r0 = n_req;
    bus_start(); send_byte({4'b1010, 3'b100, 1'b0}, a);
    chk(a == 1'b0, "R2 strap mismatch NoACK", a, 0);
    send_byte(8'h00, a);
    chk(a == 1'b0, "R2 released after mismatch", a, 0);
    bus_stop();
    bus_start(); send_byte({4'b1011, STRAP, 1'b0}, a);
    chk(a == 1'b0, "R2 prefix mismatch NoACK", a, 0);
    bus_stop();
    chk(n_req == r0, "R2 no request on mismatch", n_req, r0);
  endtask

  task automatic t_byte_write();
    logic a0, a1, a2, a3; int r0, c0;
    r0 = n_req; c0 = n_com;
    bus_start(); send_byte(DEV_W, a0); send_byte(8'hF2, a1);
    send_byte(8'h34, a2); send_byte(8'hA5, a3);
    chk(a0 & a1 & a2 & a3, "R3 ACK each master byte", {a0, a1, a2, a3}, 4'hF);
    chk(n_com == c0, "R6 no commit before STOP", n_com, c0);
    bus_stop(); #(10*CLK_PERIOD);
    chk(n_req == r0 + 1, "R5 one request per byte", n_req, r0 + 1);
    chk(log_a[r0] == 13'h1234, "R4 address upper bits ignored", log_a[r0], 13'h1234);
    chk(log_d[r0] == 8'hA5, "R5 write data", log_d[r0], 8'hA5);
    chk(n_com == c0 + 1, "R6 commit on STOP", n_com, c0 + 1);
  endtask

  task automatic t_page_write();
    logic a; int r0, c0;
    r0 = n_req; c0 = n_com;
    bus_start(); send_byte(DEV_W, a); send_byte(8'h00, a); send_byte(8'h3E, a);
    send_byte(8'h11, a); send_byte(8'h22, a); send_byte(8'h33, a);
    bus_stop(); #(10*CLK_PERIOD);
    chk(n_req == r0 + 3, "R5 page request count", n_req, r0 + 3);
    chk(log_a[r0] == 13'h003E && log_d[r0] == 8'h11, "R5 page byte 0", log_a[r0], 13'h003E);
    chk(log_a[r0+1] == 13'h003F && log_d[r0+1] == 8'h22, "R5 page byte 1", log_a[r0+1], 13'h003F);
    chk(log_a[r0+2] == 13'h0020 && log_d[r0+2] == 8'h33, "R5 page wrap", log_a[r0+2], 13'h0020);
    chk(n_com == c0 + 1, "R6 single commit per page", n_com, c0 + 1);
  endtask

  task automatic t_read_after_write();
    logic a; logic [7:0] d;
    bus_start(); send_byte(DEV_R, a);
    chk(a == 1'b1, "R9 read address ACK", a, 1);
    recv_byte(1'b0, d); bus_stop();
    chk(d == pat(13'h0021), "R11 pointer after page write", d, pat(13'h0021));
  endtask

  task automatic t_busy();
    logic a; int c0;
    c0 = n_com;
    busy = 1'b1;
    bus_start(); send_byte(DEV_W, a); bus_stop();
    chk(a == 1'b0, "R7 NoACK write while busy", a, 0);
    bus_start(); send_byte(DEV_R, a); bus_stop();
    chk(a == 1'b0, "R7 NoACK read while busy", a, 0);
    busy = 1'b0;
    bus_start(); send_byte(DEV_W, a); bus_stop();
    chk(a == 1'b1, "R7 ACK once idle", a, 1);
    #(10*CLK_PERIOD);
    chk(n_com == c0, "R6 no commit without data", n_com, c0);
  endtask

  task automatic t_wp();
    logic a0, a1, a2, a3; int r0, c0;
    r0 = n_req; c0 = n_com;
    wp = 1'b1;
    bus_start(); send_byte(DEV_W, a0); send_byte(8'h00, a1);
    send_byte(8'h10, a2); send_byte(8'h77, a3);
    bus_stop(); #(10*CLK_PERIOD);
    wp = 1'b0;
    chk(a0 & a1 & a2, "R8 address bytes ACKed", {a0, a1, a2}, 3'h7);
    chk(a3 == 1'b0, "R8 protected data NoACK", a3, 0);
    chk(n_req == r0 && n_com == c0, "R8 protected write discarded", n_req - r0 + n_com - c0, 0);
  endtask

  task automatic t_seq_read();
    logic a; logic [7:0] d0, d1, d2;
    bus_start(); send_byte(DEV_W, a); send_byte(8'hFF, a); send_byte(8'hFF, a);
    bus_start(); send_byte(DEV_R, a);
    chk(a == 1'b1, "R9 repeated START read ACK", a, 1);
    recv_byte(1'b1, d0); recv_byte(1'b1, d1); recv_byte(1'b0, d2);
    bus_stop();
    chk(d0 == pat(13'h1FFF), "R9 selective read", d0, pat(13'h1FFF));
    chk(d1 == pat(13'h0000), "R10 wrap to 0", d1, pat(13'h0000));
    chk(d2 == pat(13'h0001), "R10 sequential next", d2, pat(13'h0001));
  endtask

  task automatic t_imm_read();
    logic a; logic [7:0] d;
    bus_start(); send_byte(DEV_R, a); recv_byte(1'b0, d);
    chk(sda_oe == 1'b0, "R10 released after NoACK", sda_oe, 0);
    bus_stop();
    chk(d == pat(13'h0002), "R11 immediate read current address", d, pat(13'h0002));
  endtask

  task automatic t_abort();
    logic a; logic [7:0] d; int r0, c0;
    r0 = n_req; c0 = n_com;
    bus_start(); send_byte(DEV_W, a); send_byte(8'h05, a); bus_stop();
    bus_start(); send_byte(DEV_R, a); recv_byte(1'b0, d); bus_stop();
    chk(d == pat(13'h0003), "R12 STOP abort keeps pointer", d, pat(13'h0003));
    bus_start(); send_byte(DEV_W, a); send_byte(8'h00, a);
    bit_out(1'b0); bit_out(1'b1); bit_out(1'b1); bit_out(1'b0);
    bus_start(); send_byte(DEV_R, a);
    chk(a == 1'b1, "R12 restart mid byte ACK", a, 1);
    recv_byte(1'b0, d); bus_stop();
    chk(d == pat(13'h0004), "R12 mid byte abort keeps pointer", d, pat(13'h0004));
    #(10*CLK_PERIOD);
    chk(n_req == r0 && n_com == c0, "R12 no write from abort", n_req - r0 + n_com - c0, 0);
    bus_start(); send_byte(DEV_W, a); send_byte(8'h00, a); send_byte(8'h40, a);
    send_byte(8'h5A, a);
    bus_start(); send_byte(DEV_R, a); recv_byte(1'b0, d); bus_stop();
    #(10*CLK_PERIOD);
    chk(n_com == c0 + 1, "R12 commit kept on repeated START", n_com, c0 + 1);
    chk(n_req == r0 + 1 && log_a[r0] == 13'h0040, "R12 data before restart", log_a[r0], 13'h0040);
    chk(d == pat(13'h0041), "R11 read after write restart", d, pat(13'h0041));
  endtask

  initial begin
    #(3*CLK_PERIOD);
    rst_n = 1'b1;
    #(4*CLK_PERIOD);
    t_reset();
    t_no_start();
    t_bad_addr();
    t_byte_write();
    t_page_write();
    t_read_after_write();
    t_busy();
    t_wp();
    t_seq_read();
    t_imm_read();
    t_abort();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #(WDOG*CLK_PERIOD);
    errors = errors + 1;
    checks = checks + 1;
    $display("FAIL watchdog expired actual=0 expected=1");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule